// File: doc/BRIEF.md
# Configuration unlock guard with key sequence and complement-checked requests

This block sits in front of a bank of protected configuration registers and decides which register writes may reach them. Software opens the bank by writing four fixed key bytes, in order, to one key register. Any wrong byte, or any write to another register part-way through, throws the sequence away. Once the bank is open, writes that land in the protected address range are passed on as one-cycle commit strobes. The bank closes again on a write to a re-lock register, or after a fixed number of clock cycles.

A second path handles state-transition requests. Software writes a request byte to one register and then its bitwise inverse to a partner register. The request is committed only when the partner write is the exact complement of the held byte. A failed check drops the request and raises an error flag. A committed request carries no interrupt: the commit strobe is its only effect.

The block only produces status and strobes. The protected register contents are held elsewhere.

Top module: `cfg_unlock_guard`

## Requirements
- R1: After reset, key_ok_o is 0, unlocked_o is 0, both commit strobes are 0 and req_err_o is 0.
- R2: Writes of ABh, EFh, 56h and 12h, in that order, to KEY_ADDR set key_ok_o[0], [1], [2] and [3] one per write, in the cycle after each write. unlocked_o rises in the cycle after the fourth write.
- R3: While locked, a KEY_ADDR write whose byte is not the next expected key clears key_ok_o to 0. The next correct write must then be ABh.
- R4: While the sequence is partly entered, a write to any address other than KEY_ADDR clears key_ok_o to 0.
- R5: A write to an address in [PROT_BASE, PROT_BASE+PROT_COUNT) while unlocked gives prot_commit_o high for exactly one cycle, in the cycle after the write, with its address and data. While locked, such a write produces no strobe.
- R6: A write of any data to RELOCK_ADDR while unlocked clears unlocked_o and key_ok_o in the next cycle.
- R7: Without a re-lock, unlocked_o stays high for exactly UNLOCK_CYCLES cycles and then clears together with key_ok_o.
- R8: While unlocked, writes to KEY_ADDR, whatever their data, leave unlocked_o at 1 and key_ok_o at 4'b1111.
- R9: A write of value V to REQ_ADDR followed by a write of ~V to REQN_ADDR gives req_commit_o high for one cycle, in the cycle after the second write, with req_data_o = V (bit 1 = enable). The same commit clears req_err_o.
- R10: If the REQN_ADDR write is not the exact complement of the held value, there is no commit, req_err_o is set and the held request is dropped. req_err_o stays set until the next successful commit.
- R11: A REQN_ADDR write with no request held produces no commit and sets req_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data |
| key_ok_o | output | 4 | Key-valid bits, bit i = key i+1 accepted |
| unlocked_o | output | 1 | Protected writes allowed |
| prot_commit_o | output | 1 | Protected write commit strobe |
| prot_addr_o | output | AW | Address of committed protected write |
| prot_data_o | output | 8 | Data of committed protected write |
| req_commit_o | output | 1 | Transition request commit strobe |
| req_data_o | output | 8 | Committed request, true polarity |
| req_err_o | output | 1 | Complement check failed (sticky) |

## Verification
A stuck or skipped key stage shows on key_ok_o in the cycle after the offending write, because every key write moves the thermometer by one step or clears it. A wrong unlock timer shows as unlocked_o falling one or more cycles early or late. The bench samples the exact boundary cycle, so a timer that is off by one fails there. A corrupted held request shows in the cycle after the partner write, either as req_data_o differing from the first byte or as a commit/error outcome that does not follow from the two written bytes.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  localparam int unsigned NKEY = 4;
  localparam logic [8*NKEY-1:0] KEY_SEQ_DEF = 32'hABEF5612;

  function automatic logic [7:0] key_byte(input logic [8*NKEY-1:0] seq, input int unsigned idx);
    return seq[8*(NKEY-1-idx) +: 8];
  endfunction
endpackage

// File: rtl/key_seq_tracker.sv
module key_seq_tracker
  import cfg_unlock_pkg::*;
#(
  parameter int unsigned AW           = 6,
  parameter logic [AW-1:0] KEY_ADDR   = '0,
  parameter logic [AW-1:0] RELOCK_ADDR = '0,
  parameter logic [8*NKEY-1:0] KEY_SEQ = KEY_SEQ_DEF,
  parameter int unsigned UNLOCK_CYCLES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic [NKEY-1:0] key_ok_o,
  output logic          unlocked_o
);
  localparam int unsigned SW = $clog2(NKEY + 1);
  localparam int unsigned TW = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [SW-1:0] STAGE_OPEN = SW'(NKEY);
  localparam logic [TW-1:0] T_LAST     = TW'(UNLOCK_CYCLES - 1);

  logic [SW-1:0] stage_q, stage_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [7:0]    exp_byte;
  logic          open_q;

  assign open_q = (stage_q == STAGE_OPEN);

  always_comb begin
    exp_byte = 8'h00;
    for (int i = 0; i < int'(NKEY); i++)
      if (stage_q == SW'(i)) exp_byte = key_byte(KEY_SEQ, i);
  end

  always_comb begin
    stage_d = stage_q;
    tmr_d   = tmr_q;
    if (open_q) begin
      if ((wr_en_i && wr_addr_i == RELOCK_ADDR) || tmr_q == T_LAST) begin
        stage_d = '0;
        tmr_d   = '0;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end else if (wr_en_i) begin
      if (wr_addr_i == KEY_ADDR && wr_data_i == exp_byte) begin
        stage_d = stage_q + 1'b1;
        tmr_d   = '0;
      end else begin
        stage_d = '0;  // wrong byte or foreign write aborts
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      tmr_q   <= '0;
    end else begin
      stage_q <= stage_d;
      tmr_q   <= tmr_d;
    end
  end

  for (genvar g = 0; g < int'(NKEY); g++) begin : g_ok
    assign key_ok_o[g] = (stage_q > SW'(g));
  end
  assign unlocked_o = open_q;

  // R2
  key_thermo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((key_ok_o + 1'b1) & key_ok_o) == '0);
  // R2
  unlock_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_en_i && wr_addr_i == KEY_ADDR
                                && wr_data_i == key_byte(KEY_SEQ, NKEY-1)));
  // R6
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(unlocked_o) && $past(wr_en_i && wr_addr_i == RELOCK_ADDR)) |-> !unlocked_o && key_ok_o == '0);
  // R7
  tmr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= T_LAST);
  // R8
  open_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(unlocked_o) && unlocked_o) |-> key_ok_o == '1);
endmodule

// File: rtl/prot_write_gate.sv
module prot_write_gate #(
  parameter int unsigned AW            = 6,
  parameter logic [AW-1:0] PROT_BASE   = '0,
  parameter int unsigned PROT_COUNT    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          unlocked_i,
  output logic          commit_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam int unsigned LIM = int'(PROT_BASE) + PROT_COUNT;

  logic in_rng;
  assign in_rng = (int'(wr_addr_i) >= int'(PROT_BASE)) && (int'(wr_addr_i) < int'(LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      commit_o <= wr_en_i && in_rng && unlocked_i;
      if (wr_en_i && in_rng && unlocked_i) begin
        addr_o <= wr_addr_i;
        data_o <= wr_data_i;
      end
    end
  end

  // R5
  prot_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(unlocked_i) && $past(wr_en_i));
  // R5
  prot_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> data_o == $past(wr_data_i) && addr_o == $past(wr_addr_i));
endmodule

// File: rtl/req_pair_checker.sv
module req_pair_checker #(
  parameter int unsigned AW          = 6,
  parameter logic [AW-1:0] REQ_ADDR  = '0,
  parameter logic [AW-1:0] REQN_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic          commit_o,
  output logic [7:0]    data_o,
  output logic          err_o
);
  logic [7:0] held_q;
  logic       pend_q;
  logic       wr_req, wr_inv, match;

  assign wr_req = wr_en_i && wr_addr_i == REQ_ADDR;
  assign wr_inv = wr_en_i && wr_addr_i == REQN_ADDR;
  assign match  = pend_q && ((wr_data_i ^ held_q) == 8'hFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= '0;
      pend_q   <= 1'b0;
      commit_o <= 1'b0;
      data_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      commit_o <= wr_inv && match;
      if (wr_req) begin
        held_q <= wr_data_i;
        pend_q <= 1'b1;
      end else if (wr_inv) begin
        pend_q <= 1'b0;
        if (match) begin
          data_o <= held_q;
          err_o  <= 1'b0;
        end else begin
          err_o  <= 1'b1;
        end
      end
    end
  end

  // R9
  req_cmpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_addr_i == REQN_ADDR) && ($past(wr_data_i) == ~data_o));
  // R10
  req_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !commit_o);
  // R9
  req_err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !err_o);
endmodule

// File: rtl/cfg_unlock_guard.sv
module cfg_unlock_guard
  import cfg_unlock_pkg::*;
#(
  parameter int unsigned AW            = 6,
  parameter logic [AW-1:0] KEY_ADDR    = 6'h03,
  parameter logic [AW-1:0] RELOCK_ADDR = 6'h04,
  parameter logic [AW-1:0] REQ_ADDR    = 6'h10,
  parameter logic [AW-1:0] REQN_ADDR   = 6'h11,
  parameter logic [AW-1:0] PROT_BASE   = 6'h20,
  parameter int unsigned PROT_COUNT    = 8,
  parameter logic [8*NKEY-1:0] KEY_SEQ = KEY_SEQ_DEF,
  parameter int unsigned UNLOCK_CYCLES = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [7:0]      wr_data_i,
  output logic [NKEY-1:0] key_ok_o,
  output logic            unlocked_o,
  output logic            prot_commit_o,
  output logic [AW-1:0]   prot_addr_o,
  output logic [7:0]      prot_data_o,
  output logic            req_commit_o,
  output logic [7:0]      req_data_o,
  output logic            req_err_o
);
  key_seq_tracker #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .RELOCK_ADDR(RELOCK_ADDR),
    .KEY_SEQ(KEY_SEQ), .UNLOCK_CYCLES(UNLOCK_CYCLES)
  ) u_keys (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .key_ok_o, .unlocked_o
  );

  prot_write_gate #(.AW(AW), .PROT_BASE(PROT_BASE), .PROT_COUNT(PROT_COUNT)) u_gate (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .unlocked_i(unlocked_o),
    .commit_o(prot_commit_o), .addr_o(prot_addr_o), .data_o(prot_data_o)
  );

  req_pair_checker #(.AW(AW), .REQ_ADDR(REQ_ADDR), .REQN_ADDR(REQN_ADDR)) u_req (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .commit_o(req_commit_o), .data_o(req_data_o), .err_o(req_err_o)
  );
endmodule

// File: tb/cfg_unlock_guard_tb_top.sv
module cfg_unlock_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;
  localparam logic [5:0] A_KEY = 6'h03, A_RLK = 6'h04, A_REQ = 6'h10, A_REQN = 6'h11, A_PB = 6'h20;
  localparam logic [31:0] KEYS = 32'hABEF5612;

  logic clk = 0, rst_n = 0, we = 0;
  logic [5:0] addr = '0;
  logic [7:0] data = '0;
  logic [3:0] key_ok;
  logic unl, pc, rc, rerr;
  logic [5:0] pa;
  logic [7:0] pd, rd;

  int n_chk = 0, n_fail = 0;

  // bench model state
  int m_stage = 0, m_cnt = 0;
  bit m_pend = 0, m_err = 0, e_pc = 0, e_rc = 0;
  logic [7:0] m_held = 0, e_rd = 0;

  cfg_unlock_guard #(.UNLOCK_CYCLES(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .key_ok_o(key_ok), .unlocked_o(unl), .prot_commit_o(pc), .prot_addr_o(pa),
    .prot_data_o(pd), .req_commit_o(rc), .req_data_o(rd), .req_err_o(rerr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] kb(int i);
    return KEYS[8*(3-i) +: 8];
  endfunction

  function automatic logic [3:0] thermo(int s);
    return 4'((1 << s) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(bit w, logic [5:0] a, logic [7:0] d);
    e_pc = w && a >= A_PB && a < A_PB + 8 && m_stage == 4;
    e_rc = 0;
    if (m_stage == 4) begin
      if ((w && a == A_RLK) || m_cnt == T-1) begin m_stage = 0; m_cnt = 0; end
      else m_cnt++;
    end else if (w) begin
      if (a == A_KEY && d == kb(m_stage)) begin m_stage++; m_cnt = 0; end
      else m_stage = 0;
    end
    if (w && a == A_REQ) begin m_held = d; m_pend = 1; end
    else if (w && a == A_REQN) begin
      if (m_pend && d == ~m_held) begin e_rc = 1; e_rd = m_held; m_err = 0; end
      else m_err = 1;
      m_pend = 0;
    end
  endtask

  // one cycle; starts and ends at a negedge, compares against model
  task automatic cyc(bit w, logic [5:0] a, logic [7:0] d);
    we = w; addr = a; data = d;
    model(w, a, d);
    @(negedge clk);
    we = 0;
    chk("R2 key_ok", key_ok, thermo(m_stage));
    chk("R7 unlocked", unl, m_stage == 4);
    chk("R5 prot_commit", pc, e_pc);
    if (e_pc) begin chk("R5 prot_addr", pa, a); chk("R5 prot_data", pd, d); end
    chk("R9 req_commit", rc, e_rc);
    if (e_rc) chk("R9 req_data", rd, e_rd);
    chk("R10 req_err", rerr, m_err);
  endtask

  task automatic unlock();
    for (int i = 0; i < 4; i++) cyc(1, A_KEY, kb(i));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R1 key_ok", key_ok, 0); chk("R1 unl", unl, 0);
    chk("R1 pc", pc, 0); chk("R1 rc", rc, 0); chk("R1 err", rerr, 0);
    rst_n = 1;
    @(negedge clk);
    // R5 locked write dropped
    cyc(1, A_PB + 1, 8'h5A); chk("R5 locked", pc, 0);
    // R2 ordered key
    for (int i = 0; i < 4; i++) begin
      cyc(1, A_KEY, kb(i));
      chk("R2 step", key_ok, thermo(i + 1));
    end
    chk("R2 unlocked", unl, 1);
    // R8 key writes while unlocked ignored
    cyc(1, A_KEY, 8'h00); chk("R8 unl", unl, 1); chk("R8 key_ok", key_ok, 4'hF);
    cyc(1, A_PB + 7, 8'hC3); chk("R5 commit", pc, 1); chk("R5 data", pd, 8'hC3);
    cyc(0, 0, 0); chk("R5 one pulse", pc, 0);
    // R6 relock
    cyc(1, A_RLK, 8'h77); chk("R6 unl", unl, 0); chk("R6 key_ok", key_ok, 0);
    // R3 wrong byte, then AB restarts
    cyc(1, A_KEY, kb(0)); cyc(1, A_KEY, kb(1));
    cyc(1, A_KEY, 8'h12); chk("R3 cleared", key_ok, 0);
    cyc(1, A_KEY, kb(2)); chk("R3 no resume", key_ok, 0);
    // R4 foreign write aborts
    cyc(1, A_KEY, kb(0)); cyc(1, A_KEY, kb(1)); cyc(1, A_KEY, kb(2));
    cyc(1, A_PB, 8'h01); chk("R4 abort", key_ok, 0);
    cyc(1, A_KEY, kb(3)); chk("R4 no unlock", unl, 0);
    // R7 timeout boundary
    unlock();
    for (int k = 1; k < T; k++) cyc(0, 0, 0);
    chk("R7 last open cycle", unl, 1);
    cyc(0, 0, 0); chk("R7 closed", unl, 0); chk("R7 key_ok", key_ok, 0);
    // R9 / R10 / R11
    cyc(1, A_REQ, 8'hA5); cyc(1, A_REQN, 8'h5A);
    chk("R9 commit", rc, 1); chk("R9 data", rd, 8'hA5);
    cyc(1, A_REQ, 8'h3C); cyc(1, A_REQN, 8'h3C);
    chk("R10 no commit", rc, 0); chk("R10 err", rerr, 1);
    cyc(1, A_REQN, 8'hC3); chk("R10 dropped", rc, 0); chk("R11 err", rerr, 1);
    cyc(1, A_REQ, 8'h0F); cyc(1, A_KEY, 8'h00); cyc(1, A_REQN, 8'hF0);
    chk("R9 after gap", rc, 1); chk("R9 err clr", rerr, 0);
    cyc(1, A_REQN, 8'hF0); chk("R11 no req", rerr, 1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      logic [7:0] d = 8'($urandom);
      case (r)
        0, 1, 2: cyc(1, A_KEY, ($urandom % 4 != 0) ? kb(m_stage % 4) : d);
        3: cyc(($urandom % 4) == 0, A_RLK, d);
        4: cyc(1, A_REQ, d);
        5: cyc(1, A_REQN, ($urandom % 2) ? ~m_held : d);
        6, 7: cyc(1, A_PB + 6'($urandom % 10), d);
        default: cyc(0, 0, 0);
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule